// File: doc/BRIEF.md
# XOR-Encoded Multiported Register File

This block is a synchronous register file that accepts four writes and serves eight reads in every clock cycle. All ports share one clock. The storage is built only from simple banks, and each bank has one write port and one read port. No bank runs faster than the base clock. Each write port owns a group of banks. A value is stored in encoded form: the new data XORed with whatever the other write ports' groups currently hold at that address. A read port XORs one bank from every group and so recovers the plain value.

A write is pipelined. In the cycle it is presented, the block reads the other groups' banks at the write address. One cycle later it XORs the returned words with the new data and commits the result to every bank of its own group. Two kinds of hazard arise from this split:

- A write can read a bank that another port is committing to in that same cycle. The block corrects this stale word from a register that holds the last commit of each group.
- A read can arrive while a write to its address is still pending. The block forwards the pending data to that read.

Top module: `mprf_xor_regfile`

## Requirements
- R1: While `rst_n` is low, writes presented on any port are dropped. After reset is released, a read returns the contents from before the reset.
- R2: All 4 write ports and all 8 read ports work in the same cycle. The data for the address on read port i in cycle t appears on slice i of `rd_data` (bits i*DW upward) in cycle t+1.
- R3: A read issued two or more cycles after a write returns the data of the most recent committed write to that address.
- R4: A read issued in the same cycle as a write to the same address returns the contents from before that write.
- R5: A read issued in the cycle after a write to the same address returns the new data, forwarded from the pending write.
- R6: When several write ports target one address in the same cycle, the port with the lowest index is stored and the other writes are dropped.
- R7: When different write ports write one address in consecutive cycles, the later write is the value that reads return afterwards.
- R8: A write port whose enable bit is 0 changes no stored word, whatever its address and data are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all ports and banks |
| rst_n | input | 1 | Synchronous reset, active low; clears the write pipeline |
| wr_en | input | NW | Write enable, bit w for write port w |
| wr_addr | input | NW*AW | Write addresses; port w uses bits w*AW upward |
| wr_data | input | NW*DW | Write data; port w uses bits w*DW upward |
| rd_addr | input | NR*AW | Read addresses; port i uses bits i*AW upward |
| rd_data | output | NR*DW | Read data, one cycle after the address; port i uses bits i*DW upward |

## Verification
Every read result is due exactly one cycle after its address is presented. A write counts as done from the next cycle on. A read in that next cycle sees the write through forwarding, and a read in any later cycle sees it in the banks. The bench drives each cycle's inputs at the falling edge. It then takes a snapshot of the expected read values from its reference array, and only after that applies the cycle's writes, in reverse port order so that the lowest port wins. It compares the outputs at the next falling edge, half a period after the registering edge. Because of this ordering, the same-cycle, next-cycle and later-cycle cases of R4, R5 and R3 all fall out of a single model.

// File: rtl/mprf_pkg.sv
// Package: index helpers shared by the register file and its submodules.
// Assumes NW >= 2. Bank slots 0..NR-1 of a group feed the read ports;
// slots NR.. feed the other write ports in ascending port order.
package mprf_pkg;

    // k-th group other than group w
    function automatic int other_grp(input int k, input int w);
        return (k < w) ? k : k + 1;
    endfunction

    // slot in group g that serves the write-side read of port w
    function automatic int wr_slot(input int w, input int g, input int nr);
        return nr + ((w < g) ? w : w - 1);
    endfunction

endpackage

// File: rtl/mprf_bank.sv
// Module: one simple storage bank with one write and one read port.
// Assumes a registered read that returns the old word when the read and
// the write hit the same address at the same edge. No reset on contents.
module mprf_bank #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // store the word on an enabled write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered read, old contents on collision
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/mprf_wr_arb.sv
// Module: same-address arbitration among write ports in one cycle.
// Assumes lower port index has priority; losing writes are dropped.
module mprf_wr_arb #(
    parameter int NW = 4,
    parameter int AW = 4
) (
    input  logic [NW-1:0]         wr_en,
    input  logic [NW-1:0][AW-1:0] wa,
    output logic [NW-1:0]         win
);
    // grant each enabled port unless a lower enabled port shares its address
    always_comb begin
        for (int w = 0; w < NW; w++) begin
            win[w] = wr_en[w];
            for (int j = 0; j < w; j++) begin
                if (wr_en[j] && (wa[j] == wa[w])) win[w] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/mprf_wr_lane.sv
// Module: second stage of one write port. Holds the granted write for a
// cycle, builds the encoded word from the other groups' bank words, and
// keeps the last commit of its own group for the neighbours' correction.
// Assumes the other groups' bank reads were issued in the previous cycle
// at this lane's address, and a neighbour's last commit register holds
// what that neighbour wrote at the edge those reads were sampled.
module mprf_wr_lane #(
    parameter int NW = 4,
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  win,
    input  logic [AW-1:0]         waddr,
    input  logic [DW-1:0]         wdata,
    input  logic [NW-2:0][DW-1:0] oth_q,
    input  logic [NW-2:0]         oth_lc_vld,
    input  logic [NW-2:0][AW-1:0] oth_lc_addr,
    input  logic [NW-2:0][DW-1:0] oth_lc_enc,
    output logic                  s2_vld,
    output logic [AW-1:0]         s2_addr,
    output logic [DW-1:0]         s2_data,
    output logic [DW-1:0]         s2_enc,
    output logic                  lc_vld,
    output logic [AW-1:0]         lc_addr,
    output logic [DW-1:0]         lc_enc
);
    // valid bits of the pending write and of the last commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld <= 1'b0;
            lc_vld <= 1'b0;
        end else begin
            s2_vld <= win;
            lc_vld <= s2_vld;
        end
    end

    // address and data of the pending write and of the last commit
    always_ff @(posedge clk) begin
        s2_addr <= waddr;
        s2_data <= wdata;
        lc_addr <= s2_addr;
        lc_enc  <= s2_enc;
    end

    // encode: new data XOR the other groups' words, stale words replaced
    always_comb begin
        s2_enc = s2_data;
        for (int k = 0; k < NW - 1; k++) begin
            if (oth_lc_vld[k] && (oth_lc_addr[k] == s2_addr))
                s2_enc = s2_enc ^ oth_lc_enc[k];
            else
                s2_enc = s2_enc ^ oth_q[k];
        end
    end
endmodule

// File: rtl/mprf_rd_port.sv
// Module: one read port. XORs one bank word from each group and
// substitutes the pending write data when a write to the same address
// was in its second stage when the read was issued.
// Assumes at most one pending write per address (arbitration upstream).
module mprf_rd_port #(
    parameter int NW = 4,
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         raddr,
    input  logic [NW-1:0][DW-1:0] grp_q,
    input  logic [NW-1:0]         s2_vld,
    input  logic [NW-1:0][AW-1:0] s2_addr,
    input  logic [NW-1:0][DW-1:0] s2_data,
    output logic [DW-1:0]         rdata
);
    logic          hit_d;
    logic [DW-1:0] fwd_d;
    logic          hit_q;
    logic [DW-1:0] fwd_q;

    // find a pending write to the address being read
    always_comb begin
        hit_d = 1'b0;
        fwd_d = '0;
        for (int w = 0; w < NW; w++) begin
            if (s2_vld[w] && (s2_addr[w] == raddr)) begin
                hit_d = 1'b1;
                fwd_d = s2_data[w];
            end
        end
    end

    // register the forwarding decision alongside the bank read
    always_ff @(posedge clk) begin
        if (!rst_n) hit_q <= 1'b0;
        else        hit_q <= hit_d;
        fwd_q <= fwd_d;
    end

    // decode the groups or take the forwarded word
    always_comb begin
        rdata = '0;
        for (int g = 0; g < NW; g++) rdata = rdata ^ grp_q[g];
        if (hit_q) rdata = fwd_q;
    end
endmodule

// File: rtl/mprf_xor_regfile.sv
// Module: top of the XOR-encoded register file with NW write and NR read
// ports. Each write port owns a group of NR + NW - 1 simple banks that all
// hold the same encoded word. A write reads the other groups in its first
// cycle and commits the encoded word to its group in its second cycle.
// Assumes NW >= 2 and a single clock for all ports.
module mprf_xor_regfile #(
    parameter int NW = 4,
    parameter int NR = 8,
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NW-1:0]    wr_en,
    input  logic [NW*AW-1:0] wr_addr,
    input  logic [NW*DW-1:0] wr_data,
    input  logic [NR*AW-1:0] rd_addr,
    output logic [NR*DW-1:0] rd_data
);
    import mprf_pkg::*;

    localparam int NB = NR + NW - 1;

    logic [NW-1:0][AW-1:0] wa;
    logic [NW-1:0][DW-1:0] wd;
    logic [NR-1:0][AW-1:0] ra;
    logic [NR-1:0][DW-1:0] rq;
    logic [NW-1:0]         win;

    logic [NW-1:0]         s2_vld;
    logic [NW-1:0][AW-1:0] s2_addr;
    logic [NW-1:0][DW-1:0] s2_data;
    logic [NW-1:0][DW-1:0] s2_enc;
    logic [NW-1:0]         lc_vld;
    logic [NW-1:0][AW-1:0] lc_addr;
    logic [NW-1:0][DW-1:0] lc_enc;

    logic [DW-1:0] bank_q [NW][NB];

    assign wa      = wr_addr;
    assign wd      = wr_data;
    assign ra      = rd_addr;
    assign rd_data = rq;

    mprf_wr_arb #(.NW(NW), .AW(AW)) u_arb (
        .wr_en (wr_en),
        .wa    (wa),
        .win   (win)
    );

    // bank array: NW groups of NB banks
    for (genvar g = 0; g < NW; g++) begin : g_grp
        for (genvar s = 0; s < NB; s++) begin : g_bank
            logic [AW-1:0] b_raddr;
            if (s < NR) begin : g_rdside
                assign b_raddr = ra[s];
            end else begin : g_wrside
                localparam int WR = other_grp(s - NR, g);
                assign b_raddr = wa[WR];
            end
            mprf_bank #(.AW(AW), .DW(DW)) u_bank (
                .clk   (clk),
                .we    (s2_vld[g]),
                .waddr (s2_addr[g]),
                .wdata (s2_enc[g]),
                .raddr (b_raddr),
                .rdata (bank_q[g][s])
            );
        end
    end

    // write lanes, one per write port
    for (genvar w = 0; w < NW; w++) begin : g_lane
        logic [NW-2:0][DW-1:0] oq;
        logic [NW-2:0]         ov;
        logic [NW-2:0][AW-1:0] oa;
        logic [NW-2:0][DW-1:0] oe;
        for (genvar k = 0; k < NW - 1; k++) begin : g_oth
            localparam int G  = other_grp(k, w);
            localparam int SL = wr_slot(w, G, NR);
            assign oq[k] = bank_q[G][SL];
            assign ov[k] = lc_vld[G];
            assign oa[k] = lc_addr[G];
            assign oe[k] = lc_enc[G];
        end
        mprf_wr_lane #(.NW(NW), .AW(AW), .DW(DW)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .win         (win[w]),
            .waddr       (wa[w]),
            .wdata       (wd[w]),
            .oth_q       (oq),
            .oth_lc_vld  (ov),
            .oth_lc_addr (oa),
            .oth_lc_enc  (oe),
            .s2_vld      (s2_vld[w]),
            .s2_addr     (s2_addr[w]),
            .s2_data     (s2_data[w]),
            .s2_enc      (s2_enc[w]),
            .lc_vld      (lc_vld[w]),
            .lc_addr     (lc_addr[w]),
            .lc_enc      (lc_enc[w])
        );
    end

    // read ports, each taking its own bank from every group
    for (genvar i = 0; i < NR; i++) begin : g_rd
        logic [NW-1:0][DW-1:0] col;
        for (genvar g = 0; g < NW; g++) begin : g_col
            assign col[g] = bank_q[g][i];
        end
        mprf_rd_port #(.NW(NW), .AW(AW), .DW(DW)) u_rd (
            .clk     (clk),
            .rst_n   (rst_n),
            .raddr   (ra[i]),
            .grp_q   (col),
            .s2_vld  (s2_vld),
            .s2_addr (s2_addr),
            .s2_data (s2_data),
            .rdata   (rq[i])
        );
    end
endmodule

// File: rtl/mprf_xor_regfile_chk.sv
// Module: assertion checker bound to the register file top. Observes the
// ports and the second-stage write state.
module mprf_xor_regfile_chk #(
    parameter int NW = 4,
    parameter int NR = 8,
    parameter int AW = 4,
    parameter int DW = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NW-1:0]         wr_en,
    input logic [NW*AW-1:0]      wr_addr,
    input logic [NR*AW-1:0]      rd_addr,
    input logic [NR*DW-1:0]      rd_data,
    input logic [NW-1:0]         s2_vld,
    input logic [NW-1:0][AW-1:0] s2_addr
);
    // true when two pending writes share an address
    function automatic logic dup_commit(input logic [NW-1:0] v,
                                        input logic [NW-1:0][AW-1:0] a);
        logic d = 1'b0;
        for (int x = 0; x < NW; x++)
            for (int y = x + 1; y < NW; y++)
                if (v[x] && v[y] && a[x] == a[y]) d = 1'b1;
        return d;
    endfunction

    // R1: a write seen during reset never reaches the commit stage
    a_r1_reset_drops: assert property (@(posedge clk)
        !rst_n |=> s2_vld == '0);

    // R6: port 0 always commits when enabled
    a_r6_port0_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en[0] |=> s2_vld[0]);

    // R6: port 1 loses to port 0 on a shared address
    a_r6_loser_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[0] && wr_en[1] && wr_addr[AW-1:0] == wr_addr[2*AW-1:AW])
        |=> !s2_vld[1]);

    // R6: never two commits to one address in a cycle
    a_r6_unique_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_commit(s2_vld, s2_addr));

    // R8: no enabled port means nothing commits next cycle
    a_r8_idle_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en == '0 |=> s2_vld == '0);

    // R3: with no commits around, a held read address keeps its data
    a_r3_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_vld == '0 && $past(s2_vld) == '0 && $stable(rd_addr))
        |=> $stable(rd_data));
endmodule

bind mprf_xor_regfile mprf_xor_regfile_chk #(
    .NW(NW), .NR(NR), .AW(AW), .DW(DW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .s2_vld  (s2_vld),
    .s2_addr (s2_addr)
);

// File: tb/mprf_xor_regfile_tb.sv
`timescale 1ns/1ps
// Bench: random and directed traffic on all ports, checked against a
// reference array updated in the order the requirements define.
module mprf_xor_regfile_tb;
    localparam int NW = 4;
    localparam int NR = 8;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NW-1:0]    wr_en = '0;
    logic [NW*AW-1:0] wr_addr = '0;
    logic [NW*DW-1:0] wr_data = '0;
    logic [NR*AW-1:0] rd_addr = '0;
    logic [NR*DW-1:0] rd_data;

    logic [DW-1:0] ref_mem [DEPTH];
    bit            known [DEPTH];
    bit            we_v [NW];
    logic [AW-1:0] wa_v [NW];
    logic [DW-1:0] wd_v [NW];
    logic [AW-1:0] ra_v [NR];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mprf_xor_regfile #(.NW(NW), .NR(NR), .AW(AW), .DW(DW)) u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data)
    );

    task automatic check(input bit ok, input string tag, input int port,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s read port %0d: actual %h expected %h", tag, port, act, exp);
        end
    endtask

    task automatic clear_ports();
        for (int w = 0; w < NW; w++) begin we_v[w] = 0; wa_v[w] = '0; wd_v[w] = '0; end
        for (int i = 0; i < NR; i++) ra_v[i] = '0;
    endtask

    // one cycle: drive at falling edge, snapshot reads, apply writes, compare
    task automatic step(input string tag);
        logic [DW-1:0] exp_v [NR];
        bit            chk_v [NR];
        bit            live;
        live = rst_n;
        for (int w = 0; w < NW; w++) begin
            wr_en[w] = we_v[w];
            wr_addr[w*AW +: AW] = wa_v[w];
            wr_data[w*DW +: DW] = wd_v[w];
        end
        for (int i = 0; i < NR; i++) begin
            rd_addr[i*AW +: AW] = ra_v[i];
            exp_v[i] = ref_mem[ra_v[i]];
            chk_v[i] = live && known[ra_v[i]];
        end
        if (live) begin
            for (int w = NW - 1; w >= 0; w--) begin
                if (we_v[w]) begin ref_mem[wa_v[w]] = wd_v[w]; known[wa_v[w]] = 1; end
            end
        end
        @(negedge clk);
        for (int i = 0; i < NR; i++) begin
            if (chk_v[i]) check(rd_data[i*DW +: DW] === exp_v[i], tag, i,
                                rd_data[i*DW +: DW], exp_v[i]);
        end
    endtask

    // watchdog: a hung run counts as a failure
    initial begin
        #500000;
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int a = 0; a < DEPTH; a++) begin ref_mem[a] = '0; known[a] = 0; end
        clear_ports();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // fill every address, all write ports at once (R2)
        for (int a = 0; a < DEPTH; a += NW) begin
            clear_ports();
            for (int w = 0; w < NW; w++) begin
                we_v[w] = 1; wa_v[w] = AW'(a + w); wd_v[w] = DW'($urandom);
            end
            step("R2 fill");
        end
        clear_ports();
        for (int i = 0; i < NR; i++) ra_v[i] = AW'(i);
        step("R3 after fill");
        step("R3 after fill");

        // R1: writes during reset are dropped
        rst_n = 1'b0;
        for (int w = 0; w < NW; w++) begin we_v[w] = 1; wa_v[w] = AW'(w); wd_v[w] = 16'hDEAD; end
        step("R1 in reset");
        step("R1 in reset");
        rst_n = 1'b1;
        clear_ports();
        for (int i = 0; i < NR; i++) ra_v[i] = AW'(i % NW);
        step("R1 after reset");

        // R4 then R5: same-cycle read old, next-cycle read forwarded
        clear_ports();
        we_v[2] = 1; wa_v[2] = 4'd5; wd_v[2] = 16'h1234;
        for (int i = 0; i < NR; i++) ra_v[i] = 4'd5;
        step("R4 same cycle");
        clear_ports();
        for (int i = 0; i < NR; i++) ra_v[i] = 4'd5;
        step("R5 next cycle");
        step("R3 later cycle");

        // R6: all ports on one address, then ports 1 and 3 on another
        clear_ports();
        for (int w = 0; w < NW; w++) begin we_v[w] = 1; wa_v[w] = 4'd7; wd_v[w] = DW'(16'hA000 + w); end
        step("R6 all same addr");
        clear_ports();
        we_v[1] = 1; wa_v[1] = 4'd8; wd_v[1] = 16'hB001;
        we_v[3] = 1; wa_v[3] = 4'd8; wd_v[3] = 16'hB003;
        for (int i = 0; i < NR; i++) ra_v[i] = 4'd7;
        step("R6 read winner");
        clear_ports();
        for (int i = 0; i < NR; i++) ra_v[i] = (i < 4) ? 4'd7 : 4'd8;
        step("R6 read winner");
        step("R6 read winner");

        // R7: ports 0, 3, 1 write address 9 in consecutive cycles
        clear_ports(); we_v[0] = 1; wa_v[0] = 4'd9; wd_v[0] = 16'hC000; step("R7 chain");
        clear_ports(); we_v[3] = 1; wa_v[3] = 4'd9; wd_v[3] = 16'hC003;
        for (int i = 0; i < NR; i++) ra_v[i] = 4'd9;
        step("R7 chain");
        clear_ports(); we_v[1] = 1; wa_v[1] = 4'd9; wd_v[1] = 16'hC001;
        for (int i = 0; i < NR; i++) ra_v[i] = 4'd9;
        step("R7 chain");
        clear_ports();
        for (int i = 0; i < NR; i++) ra_v[i] = 4'd9;
        step("R7 final");
        step("R7 final");

        // R8: disabled ports with live address and data change nothing
        clear_ports();
        for (int w = 0; w < NW; w++) begin wa_v[w] = 4'd9; wd_v[w] = 16'hFFFF; end
        step("R8 disabled");
        for (int i = 0; i < NR; i++) ra_v[i] = 4'd9;
        step("R8 disabled");
        step("R8 disabled");

        // random traffic on every port (R2, R3, with R6 and R7 collisions)
        for (int c = 0; c < 3000; c++) begin
            for (int w = 0; w < NW; w++) begin
                we_v[w] = ($urandom % 3) != 0;
                wa_v[w] = AW'($urandom);
                wd_v[w] = DW'($urandom);
            end
            for (int i = 0; i < NR; i++) ra_v[i] = AW'($urandom);
            step("R2 R3 random");
        end
        clear_ports();
        for (int i = 0; i < NR; i++) ra_v[i] = AW'(i);
        step("R3 drain");
        step("R3 drain");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule